// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block holds a 16-bit timer that counts block-clock ticks through a selectable prescaler, and a 16-bit compare value. While a compare mode is selected, the timer is compared with the compare value on every clock. A match can set an output latch high, clear it low, only raise a sticky interrupt flag, or fire an event trigger. The event trigger clears the timer and emits a one-cycle conversion-start pulse. In that mode the compare value acts as a programmable period, and the overflow flag stays clear.

Software reaches the block through a byte-wide write bus. The timer value, the output latch, both flags and the conversion-start pulse come out as ports. The timer always counts on the block clock, so the compare result is always valid.

Register map (3-bit address):
- 0: timer low byte.
- 1: timer high byte.
- 2: compare low byte.
- 3: compare high byte.
- 4: mode, bits [3:0].
- 5: control. Bit 0 enables the timer. Bits [2:1] select the prescale: 0 divides by 1, 1 by 2, 2 by 4, 3 by 8.
- 6: flags. Bit 0 is the compare flag and bit 1 is the overflow flag. Writing 0 to a bit clears that flag; writing 1 leaves it as it is.

Top module: `tmr_compare`

## Requirements
- R1: While enabled with prescale select s, the timer increments by one every 2^s clocks. Writes to address 0 or 1 load the low or high timer byte, and a bus write to the timer takes priority over counting. The prescale phase restarts from zero when the timer is disabled, written or cleared by the trigger.
- R2: A count step from 0xFFFF to 0x0000 sets the overflow flag (flags bit 1) on the same edge that the timer wraps.
- R3: In mode 4'b1000 a match sets the output latch to 1, and in mode 4'b1001 a match clears it to 0. The latch changes on the clock edge after the first cycle in which the timer equals the compare value. The compare flag (flags bit 0) is set on that same edge.
- R4: In mode 4'b1010 a match sets the compare flag and leaves the output latch unchanged.
- R5: In mode 4'b1011 a match clears the timer to zero on the next edge and raises conv_start for exactly one cycle. The overflow flag is not set. With compare value C ≥ 1 and prescale 2^s, conv_start pulses repeat every C·2^s + 1 clocks.
- R6: Writing 4'b0000 or 4'b1000 to the mode register forces the output latch to 0. Writing 4'b1001 forces it to 1. Any mode value whose top two bits are not 2'b10 disables matching.
- R7: A match is acted on once per timer value. While the timer holds the matching value, a cleared compare flag stays clear.
- R8: Both flags are sticky until cleared by a flag write. A hardware set in the same cycle as a clear wins.
- R9: After reset the timer, compare value, mode, control, latch, flags and conv_start are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| timer_val | output | 16 | Current timer value |
| cmp_out | output | 1 | Compare output latch |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
Random start values and prescale settings exercise plain counting; these tests separate a correct divide ratio from an off-by-one phase. Directed wrap tests show that the overflow flag comes only from the natural 0xFFFF step. Random compare values and prescales in trigger mode are checked against the period formula C·2^s + 1, which catches a prescaler that is not restarted and a trigger that lands one tick late. Each latch mode is run with the latch preset to the level a wrong action would leave. A flag cleared during a long prescaled hold separates single-shot matching from matching on every clock.

// File: rtl/tmr_compare.sv
module tmr_compare (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] timer_val,
  output logic        cmp_out,
  output logic        cmp_flag,
  output logic        ovf_flag,
  output logic        conv_start
);

  logic [15:0] tmr_q, tmr_nxt, cmp_q;
  logic [3:0]  mode_q;
  logic        en_q;
  logic [1:0]  ps_q;
  logic [2:0]  pre_q, pmask;
  logic        out_q, cflag_q, oflag_q, conv_q, done_q;

  wire wr_tlo  = bus_wr && bus_addr == 3'd0;
  wire wr_thi  = bus_wr && bus_addr == 3'd1;
  wire wr_clo  = bus_wr && bus_addr == 3'd2;
  wire wr_chi  = bus_wr && bus_addr == 3'd3;
  wire wr_mode = bus_wr && bus_addr == 3'd4;
  wire wr_ctrl = bus_wr && bus_addr == 3'd5;
  wire wr_flag = bus_wr && bus_addr == 3'd6;
  wire tmr_wr  = wr_tlo || wr_thi;

  assign pmask = 3'((4'd1 << ps_q) - 4'd1);
  wire tick    = en_q && ((pre_q & pmask) == pmask);
  wire mode_on = mode_q[3:2] == 2'b10;
  wire hit     = mode_on && (tmr_q == cmp_q) && !done_q;
  wire trig    = hit && mode_q[1:0] == 2'b11;
  wire wrap    = tick && tmr_q == 16'hFFFF && !trig && !tmr_wr;

  always_comb begin
    tmr_nxt = tmr_q;
    if (wr_tlo)      tmr_nxt[7:0]  = bus_wdata;
    else if (wr_thi) tmr_nxt[15:8] = bus_wdata;
    else if (trig)   tmr_nxt       = 16'h0000;
    else if (tick)   tmr_nxt       = tmr_q + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      cmp_q   <= '0;
      mode_q  <= '0;
      en_q    <= 1'b0;
      ps_q    <= '0;
      pre_q   <= '0;
      out_q   <= 1'b0;
      cflag_q <= 1'b0;
      oflag_q <= 1'b0;
      conv_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      tmr_q  <= tmr_nxt;
      conv_q <= trig;
      done_q <= (tmr_nxt == tmr_q) ? (done_q | hit) : 1'b0;

      if (!en_q || trig || tmr_wr || tick) pre_q <= '0;
      else                                 pre_q <= pre_q + 3'd1;

      if (wr_clo) cmp_q[7:0]  <= bus_wdata;
      if (wr_chi) cmp_q[15:8] <= bus_wdata;
      if (wr_ctrl) begin
        en_q <= bus_wdata[0];
        ps_q <= bus_wdata[2:1];
      end

      if (wr_mode) begin
        mode_q <= bus_wdata[3:0];
        case (bus_wdata[3:0])
          4'b0000, 4'b1000: out_q <= 1'b0;
          4'b1001:          out_q <= 1'b1;
          default:          ;
        endcase
      end else if (hit && mode_q == 4'b1000) out_q <= 1'b1;
      else if (hit && mode_q == 4'b1001)     out_q <= 1'b0;

      if (hit)                             cflag_q <= 1'b1;
      else if (wr_flag && !bus_wdata[0])   cflag_q <= 1'b0;
      if (wrap)                            oflag_q <= 1'b1;
      else if (wr_flag && !bus_wdata[1])   oflag_q <= 1'b0;
    end
  end

  assign timer_val  = tmr_q;
  assign cmp_out    = out_q;
  assign cmp_flag   = cflag_q;
  assign ovf_flag   = oflag_q;
  assign conv_start = conv_q;

  a_r2_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oflag_q) |-> $past(tmr_q) == 16'hFFFF && tmr_q == 16'h0000);
  a_r3_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cflag_q);
  a_r4_pin_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode_q == 4'b1010 && !wr_mode) |=> $stable(out_q));
  a_r5_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !tmr_wr) |=> tmr_q == 16'h0000 && conv_q && !$rose(oflag_q));
  a_r5_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q |=> !conv_q);
  a_r6_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && bus_wdata[3:0] == 4'b0000) |=> !out_q);
  a_r7_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && tmr_nxt == tmr_q && !wr_mode && !wr_clo && !wr_chi) |=> !hit);

endmodule

// File: tb/tb_tmr_compare.sv
`timescale 1ns/1ps
module tb_tmr_compare;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [15:0] timer_val;
  logic cmp_out, cmp_flag, ovf_flag, conv_start;
  int checks = 0, fails = 0;
  bit reported = 0;

  tmr_compare dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .timer_val(timer_val), .cmp_out(cmp_out),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .conv_start(conv_start));

  always #5 clk = ~clk;

  function automatic int exp_period(int c, int s);
    return c * (1 << s) + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(logic [15:0] t, logic [15:0] c, logic [3:0] m);
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    wr(3'd0, t[7:0]); wr(3'd1, t[15:8]);
    wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
    wr(3'd4, {4'h0, m});
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 timer", timer_val, 0);
    chk("R9 latch", cmp_out, 0);
    chk("R9 cmp flag", cmp_flag, 0);
    chk("R9 ovf flag", ovf_flag, 0);
    chk("R9 conv", conv_start, 0);

    // R1 random counting with prescale
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      int s, k;
      v = 16'($urandom % 16'hFF00);
      s = int'($urandom % 4);
      k = 1 + int'($urandom % 20);
      setup(v, 16'h0000, 4'h0);
      wr(3'd5, {5'b0, 2'(s), 1'b1});
      step(k * (1 << s));
      chk("R1 count", timer_val, int'(16'(v + 16'(k))));
    end

    // R2 wrap sets overflow
    setup(16'hFFFE, 16'h0000, 4'h0);
    wr(3'd5, 8'h01);
    step(1);
    chk("R2 before wrap", ovf_flag, 0);
    step(1);
    chk("R2 wrap timer", timer_val, 0);
    chk("R2 wrap flag", ovf_flag, 1);
    step(5);
    chk("R8 ovf sticky", ovf_flag, 1);
    wr(3'd6, 8'h01);
    chk("R8 ovf cleared", ovf_flag, 0);

    // R3 set-high
    setup(16'h0000, 16'h0005, 4'h8);
    chk("R6 set-high starts low", cmp_out, 0);
    wr(3'd5, 8'h01);
    step(5);
    chk("R3 high before", cmp_out, 0);
    chk("R3 flag before", cmp_flag, 0);
    step(1);
    chk("R3 high after", cmp_out, 1);
    chk("R3 flag after", cmp_flag, 1);

    // R4 interrupt-only keeps latch high
    setup(16'h0000, 16'h0003, 4'hA);
    chk("R4 latch kept on mode write", cmp_out, 1);
    wr(3'd5, 8'h01);
    step(3);
    chk("R4 flag before", cmp_flag, 0);
    step(1);
    chk("R4 flag after", cmp_flag, 1);
    chk("R4 latch unchanged", cmp_out, 1);

    // R6 clear mode forces latch low
    wr(3'd4, 8'h00);
    chk("R6 zero mode clears", cmp_out, 0);

    // R3 set-low
    setup(16'h0000, 16'h0004, 4'h9);
    chk("R6 set-low starts high", cmp_out, 1);
    wr(3'd5, 8'h01);
    step(4);
    chk("R3 low before", cmp_out, 1);
    step(1);
    chk("R3 low after", cmp_out, 0);
    chk("R3 low flag", cmp_flag, 1);

    // R6 non-compare mode: no match
    setup(16'h0000, 16'h0002, 4'h4);
    wr(3'd5, 8'h01);
    step(5);
    chk("R6 disabled no flag", cmp_flag, 0);

    // R7 single action per value under prescale 8
    setup(16'h0000, 16'h0002, 4'h8);
    wr(3'd5, 8'h07);
    step(17);
    chk("R7 first match flag", cmp_flag, 1);
    chk("R7 first match latch", cmp_out, 1);
    wr(3'd6, 8'h00);
    step(2);
    chk("R7 still holding value", timer_val, 2);
    chk("R7 flag stays clear", cmp_flag, 0);

    // R5 trigger period with random compare and prescale
    for (int i = 0; i < 6; i++) begin
      int c, s, n;
      c = 1 + int'($urandom % 30);
      s = int'($urandom % 4);
      setup(16'h0000, 16'(c), 4'hB);
      wr(3'd5, {5'b0, 2'(s), 1'b1});
      n = 0;
      while (!conv_start && n < 2000) begin @(negedge clk); n++; end
      chk("R5 first pulse seen", conv_start, 1);
      chk("R5 timer cleared", timer_val, 0);
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) chk("R5 one-cycle pulse", conv_start, 0);
      end while (!conv_start && n < 2000);
      chk("R5 period", n, exp_period(c, s));
      chk("R5 no overflow", ovf_flag, 0);
    end

    // R5 trigger at 0xFFFF must not set overflow
    setup(16'hFFFD, 16'hFFFF, 4'hB);
    wr(3'd5, 8'h01);
    step(3);
    chk("R5 top trigger pulse", conv_start, 1);
    chk("R5 top trigger timer", timer_val, 0);
    chk("R5 top trigger no ovf", ovf_flag, 0);

    finish_run();
  end
endmodule